// File: doc/BRIEF.md
# Platform System Control Register Block

This block is a byte-wide register file on a synchronous I/O-port bus. It answers a single port at 0x0092 and a window of ports from 0x0800 to 0x0851 of a legacy workstation platform. Reads return fixed identification and equipment codes, or the state of a few writable control bits. Writes set the byte-order select, the disk activity light, a 4-bit system control field and the I/O map type bit. The map type bit is consumed by the platform's address translator.

Some writes have side effects outside the block. These are a soft reset request, toggles of two NVRAM lock latches and an L2 cache invalidate. Each is signalled by a single-cycle strobe. Read data is registered and appears one clock after the read is accepted. Addresses that are not decoded read as 0xFF, and writes to them do nothing.

Top module: `sys_ctrl_regs`

## Requirements
- R1: While rst_ni is low, all control outputs, all strobes and rdata_o are 0.
- R2: A write to 0x0092 loads wdata_i bit 1 into little_endian_o (1 = little-endian, 0 = big-endian). If wdata_i bit 0 is 1, the write also pulses soft_reset_o. A read of 0x0092 returns 0x00.
- R3: Reads of the fixed ports return these codes: 0x0800 → 0xEF, 0x0802 → 0xAD, 0x0803 → 0xE0, 0x080C → 0x3C, 0x0810 → 0x39, 0x0818 → 0x00, 0x0823 → 0x03. Writes to 0x0800, 0x0802 and 0x0803 change no output.
- R4: A write to 0x0808 loads wdata_i bit 0 into disk_light_o. A read of 0x0808 returns 0xFF.
- R5: A write to 0x0810 pulses nvram_lock1_tgl_o and a write to 0x0812 pulses nvram_lock2_tgl_o, whatever the data. A read of 0x0812 returns 0xFF.
- R6: A write to 0x0814 pulses l2_inval_o, whatever the data. A read of 0x0814 returns 0xFF.
- R7: A write to 0x081C stores wdata_i[3:0] on sys_ctrl_o. A read of 0x081C returns {4'b0000, stored value}.
- R8: A write to 0x0850 stores wdata_i bit 0 on map_type_o. A read of 0x0850 returns {7'b0, stored bit}.
- R9: A read of any other address returns 0xFF. A write to any other address changes no output.
- R10: Each strobe is high for exactly the one clock cycle that follows the rising edge at which its write is accepted. Without such a write the strobe stays low.
- R11: rdata_o is loaded at a rising edge where rd_en_i is high and holds its value otherwise. A read and a write accepted at the same edge return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Port address |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write accepted at this rising edge |
| rd_en_i | input | 1 | Read accepted at this rising edge |
| rdata_o | output | 8 | Registered read data |
| little_endian_o | output | 1 | Byte order select, 1 = little-endian |
| disk_light_o | output | 1 | Disk activity light |
| sys_ctrl_o | output | 4 | System control field |
| map_type_o | output | 1 | I/O map type for the address translator |
| soft_reset_o | output | 1 | Soft reset request strobe |
| nvram_lock1_tgl_o | output | 1 | NVRAM lock 1 toggle strobe |
| nvram_lock2_tgl_o | output | 1 | NVRAM lock 2 toggle strobe |
| l2_inval_o | output | 1 | L2 invalidate strobe |

## Verification
The assertions assume that addr_i, wdata_i, wr_en_i and rd_en_i are stable around each rising edge. They also assume that a read and a write in the same cycle target a single address. The stimulus changes every input only on the falling edge, and each operation drives one address.

The random stimulus mostly draws from the decoded ports and their neighbours just inside and outside the window, such as 0x0801, 0x0851, 0x0852 and 0x0093. Fully random addresses are mixed in. Read and write enables are set independently, so simultaneous read-write cycles and back-to-back strobes both occur.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

  typedef enum logic [3:0] {
    PORT_NONE,
    PORT_SPECIAL,
    PORT_CPU_ID,
    PORT_FEAT,
    PORT_STAT,
    PORT_LIGHT,
    PORT_EQUIP,
    PORT_LOCK1,
    PORT_LOCK2,
    PORT_INVAL,
    PORT_KEYLOCK,
    PORT_SYSCTL,
    PORT_CACHE,
    PORT_MAP
  } port_e;

  localparam logic [15:0] A_SPECIAL = 16'h0092;
  localparam logic [15:0] A_CPU_ID  = 16'h0800;
  localparam logic [15:0] A_FEAT    = 16'h0802;
  localparam logic [15:0] A_STAT    = 16'h0803;
  localparam logic [15:0] A_LIGHT   = 16'h0808;
  localparam logic [15:0] A_EQUIP   = 16'h080C;
  localparam logic [15:0] A_LOCK1   = 16'h0810;
  localparam logic [15:0] A_LOCK2   = 16'h0812;
  localparam logic [15:0] A_INVAL   = 16'h0814;
  localparam logic [15:0] A_KEYLOCK = 16'h0818;
  localparam logic [15:0] A_SYSCTL  = 16'h081C;
  localparam logic [15:0] A_CACHE   = 16'h0823;
  localparam logic [15:0] A_MAP     = 16'h0850;

  localparam logic [7:0] C_SPECIAL = 8'h00;
  localparam logic [7:0] C_CPU_ID  = 8'hEF;
  localparam logic [7:0] C_FEAT    = 8'hAD;
  localparam logic [7:0] C_STAT    = 8'hE0;
  localparam logic [7:0] C_EQUIP   = 8'h3C;
  localparam logic [7:0] C_EXTFEAT = 8'h39;
  localparam logic [7:0] C_KEYLOCK = 8'h00;
  localparam logic [7:0] C_CACHE   = 8'h03;

  localparam int STB_SOFT_RST = 0;
  localparam int STB_LOCK1    = 1;
  localparam int STB_LOCK2    = 2;
  localparam int STB_INVAL    = 3;
  localparam int NUM_STB      = 4;

endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode
  import sysreg_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  output port_e             sel_o
);

  always_comb begin
    case (addr_i)
      ADDR_W'(A_SPECIAL): sel_o = PORT_SPECIAL;
      ADDR_W'(A_CPU_ID):  sel_o = PORT_CPU_ID;
      ADDR_W'(A_FEAT):    sel_o = PORT_FEAT;
      ADDR_W'(A_STAT):    sel_o = PORT_STAT;
      ADDR_W'(A_LIGHT):   sel_o = PORT_LIGHT;
      ADDR_W'(A_EQUIP):   sel_o = PORT_EQUIP;
      ADDR_W'(A_LOCK1):   sel_o = PORT_LOCK1;
      ADDR_W'(A_LOCK2):   sel_o = PORT_LOCK2;
      ADDR_W'(A_INVAL):   sel_o = PORT_INVAL;
      ADDR_W'(A_KEYLOCK): sel_o = PORT_KEYLOCK;
      ADDR_W'(A_SYSCTL):  sel_o = PORT_SYSCTL;
      ADDR_W'(A_CACHE):   sel_o = PORT_CACHE;
      ADDR_W'(A_MAP):     sel_o = PORT_MAP;
      default:            sel_o = PORT_NONE;
    endcase
  end

endmodule

// File: rtl/sysreg_ctrl.sv
module sysreg_ctrl
  import sysreg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CTRL_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  port_e             sel_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              little_endian_o,
  output logic              disk_light_o,
  output logic [CTRL_W-1:0] sys_ctrl_o,
  output logic              map_type_o,
  output logic [NUM_STB-1:0] stb_o
);

  logic              le_q, light_q, map_q;
  logic [CTRL_W-1:0] sys_ctrl_q;
  logic [NUM_STB-1:0] stb_req, stb_q;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:CTRL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      le_q       <= 1'b0;
      light_q    <= 1'b0;
      sys_ctrl_q <= '0;
      map_q      <= 1'b0;
    end else if (wr_en_i) begin
      case (sel_i)
        PORT_SPECIAL: le_q       <= wdata_i[1];
        PORT_LIGHT:   light_q    <= wdata_i[0];
        PORT_SYSCTL:  sys_ctrl_q <= wdata_i[CTRL_W-1:0];
        PORT_MAP:     map_q      <= wdata_i[0];
        default: ;
      endcase
    end
  end

  // side-effect requests, registered into one-cycle pulses
  always_comb begin
    stb_req = '0;
    if (wr_en_i) begin
      case (sel_i)
        PORT_SPECIAL: stb_req[STB_SOFT_RST] = wdata_i[0];
        PORT_LOCK1:   stb_req[STB_LOCK1]    = 1'b1;
        PORT_LOCK2:   stb_req[STB_LOCK2]    = 1'b1;
        PORT_INVAL:   stb_req[STB_INVAL]    = 1'b1;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_STB; g++) begin : g_stb
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stb_q[g] <= 1'b0;
      else         stb_q[g] <= stb_req[g];
    end
  end

  assign little_endian_o = le_q;
  assign disk_light_o    = light_q;
  assign sys_ctrl_o      = sys_ctrl_q;
  assign map_type_o      = map_q;
  assign stb_o           = stb_q;

  // R10
  soft_reset_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i == PORT_SPECIAL && wdata_i[0]) |=> stb_o[STB_SOFT_RST]);

  // R10
  no_spurious_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (stb_o == '0));

  // R7
  sysctl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && sel_i == PORT_SYSCTL) |=> $stable(sys_ctrl_o));

  // R8
  map_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i == PORT_MAP) |=> (map_type_o == $past(wdata_i[0])));

endmodule

// File: rtl/sysreg_rdmux.sv
module sysreg_rdmux
  import sysreg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CTRL_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  port_e             sel_i,
  input  logic              rd_en_i,
  input  logic [CTRL_W-1:0] sys_ctrl_i,
  input  logic              map_type_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] rd_next, rdata_q;

  always_comb begin
    case (sel_i)
      PORT_SPECIAL: rd_next = DATA_W'(C_SPECIAL);
      PORT_CPU_ID:  rd_next = DATA_W'(C_CPU_ID);
      PORT_FEAT:    rd_next = DATA_W'(C_FEAT);
      PORT_STAT:    rd_next = DATA_W'(C_STAT);
      PORT_EQUIP:   rd_next = DATA_W'(C_EQUIP);
      PORT_LOCK1:   rd_next = DATA_W'(C_EXTFEAT);
      PORT_KEYLOCK: rd_next = DATA_W'(C_KEYLOCK);
      PORT_CACHE:   rd_next = DATA_W'(C_CACHE);
      PORT_SYSCTL:  rd_next = DATA_W'(sys_ctrl_i);
      PORT_MAP:     rd_next = DATA_W'(map_type_i);
      default:      rd_next = '1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_next;
  end

  assign rdata_o = rdata_q;

  // R11
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));

  // R9
  unmapped_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && sel_i == PORT_NONE) |=> (rdata_o == {DATA_W{1'b1}}));

endmodule

// File: rtl/sys_ctrl_regs.sv
module sys_ctrl_regs
  import sysreg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CTRL_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              little_endian_o,
  output logic              disk_light_o,
  output logic [CTRL_W-1:0] sys_ctrl_o,
  output logic              map_type_o,
  output logic              soft_reset_o,
  output logic              nvram_lock1_tgl_o,
  output logic              nvram_lock2_tgl_o,
  output logic              l2_inval_o
);

  port_e              sel;
  logic [NUM_STB-1:0] stb;

  sysreg_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  sysreg_ctrl #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .sel_i           (sel),
    .wr_en_i         (wr_en_i),
    .wdata_i         (wdata_i),
    .little_endian_o (little_endian_o),
    .disk_light_o    (disk_light_o),
    .sys_ctrl_o      (sys_ctrl_o),
    .map_type_o      (map_type_o),
    .stb_o           (stb)
  );

  sysreg_rdmux #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_rdmux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel),
    .rd_en_i    (rd_en_i),
    .sys_ctrl_i (sys_ctrl_o),
    .map_type_i (map_type_o),
    .rdata_o    (rdata_o)
  );

  assign soft_reset_o      = stb[STB_SOFT_RST];
  assign nvram_lock1_tgl_o = stb[STB_LOCK1];
  assign nvram_lock2_tgl_o = stb[STB_LOCK2];
  assign l2_inval_o        = stb[STB_INVAL];

  // R5
  lock_strobes_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({nvram_lock1_tgl_o, nvram_lock2_tgl_o, l2_inval_o, soft_reset_o}));

endmodule

// File: tb/sys_ctrl_regs_test.sv
`timescale 1ns/1ps
module sys_ctrl_regs_test;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic [15:0] addr_i;
  logic [7:0]  wdata_i;
  logic        wr_en_i, rd_en_i;
  logic [7:0]  rdata_o;
  logic        little_endian_o, disk_light_o, map_type_o;
  logic [3:0]  sys_ctrl_o;
  logic        soft_reset_o, nvram_lock1_tgl_o, nvram_lock2_tgl_o, l2_inval_o;

  always #2 clk = ~clk;

  sys_ctrl_regs uut (
    .clk_i (clk), .rst_ni (rst_ni), .addr_i (addr_i), .wdata_i (wdata_i),
    .wr_en_i (wr_en_i), .rd_en_i (rd_en_i), .rdata_o (rdata_o),
    .little_endian_o (little_endian_o), .disk_light_o (disk_light_o),
    .sys_ctrl_o (sys_ctrl_o), .map_type_o (map_type_o),
    .soft_reset_o (soft_reset_o), .nvram_lock1_tgl_o (nvram_lock1_tgl_o),
    .nvram_lock2_tgl_o (nvram_lock2_tgl_o), .l2_inval_o (l2_inval_o)
  );

  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 1'b0;
  bit   m_le, m_light, m_map;
  logic [3:0] m_sys;
  logic [7:0] m_rd;

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(logic [15:0] a);
    case (a)
      16'h0092: return 8'h00;
      16'h0800: return 8'hEF;
      16'h0802: return 8'hAD;
      16'h0803: return 8'hE0;
      16'h080C: return 8'h3C;
      16'h0810: return 8'h39;
      16'h0818: return 8'h00;
      16'h0823: return 8'h03;
      16'h081C: return {4'b0000, m_sys};
      16'h0850: return {7'b0, m_map};
      default:  return 8'hFF;
    endcase
  endfunction

  function automatic string rd_tag(logic [15:0] a);
    case (a)
      16'h0092: return "R2/R11";
      16'h0800, 16'h0802, 16'h0803, 16'h080C, 16'h0810,
      16'h0818, 16'h0823: return "R3/R11";
      16'h0808: return "R4/R11";
      16'h0812: return "R5/R11";
      16'h0814: return "R6/R11";
      16'h081C: return "R7/R11";
      16'h0850: return "R8/R11";
      default:  return "R9/R11";
    endcase
  endfunction

  function automatic logic [15:0] rand_addr();
    case ($urandom % 22)
      0:  return 16'h0092;  1:  return 16'h0800;  2:  return 16'h0802;
      3:  return 16'h0803;  4:  return 16'h0808;  5:  return 16'h080C;
      6:  return 16'h0810;  7:  return 16'h0812;  8:  return 16'h0814;
      9:  return 16'h0818;  10: return 16'h081C;  11: return 16'h0823;
      12: return 16'h0850;  13: return 16'h0801;  14: return 16'h0851;
      15: return 16'h0852;  16: return 16'h0093;  17: return 16'h07FF;
      18: return 16'h0091;  19: return 16'h081D;
      default: return 16'($urandom);
    endcase
  endfunction

  // called at a falling edge; checks every output after the next rising edge
  task automatic step(logic [15:0] a, logic [7:0] d, bit we, bit re);
    bit e_soft, e_l1, e_l2, e_inv;
    string rt;
    addr_i = a; wdata_i = d; wr_en_i = we; rd_en_i = re;
    rt = re ? rd_tag(a) : "R11";
    if (re) m_rd = exp_read(a);
    e_soft = we && a == 16'h0092 && d[0];
    e_l1   = we && a == 16'h0810;
    e_l2   = we && a == 16'h0812;
    e_inv  = we && a == 16'h0814;
    if (we) begin
      case (a)
        16'h0092: m_le    = d[1];
        16'h0808: m_light = d[0];
        16'h081C: m_sys   = d[3:0];
        16'h0850: m_map   = d[0];
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    wr_en_i = 1'b0; rd_en_i = 1'b0;
    chk(rt,       "rdata",  rdata_o, m_rd);
    chk("R2/R9",  "endian", {7'b0, little_endian_o}, {7'b0, m_le});
    chk("R4/R9",  "light",  {7'b0, disk_light_o}, {7'b0, m_light});
    chk("R7/R9",  "sysctl", {4'b0, sys_ctrl_o}, {4'b0, m_sys});
    chk("R8/R9",  "map",    {7'b0, map_type_o}, {7'b0, m_map});
    chk("R2/R10", "soft",   {7'b0, soft_reset_o}, {7'b0, e_soft});
    chk("R5/R10", "lock1",  {7'b0, nvram_lock1_tgl_o}, {7'b0, e_l1});
    chk("R5/R10", "lock2",  {7'b0, nvram_lock2_tgl_o}, {7'b0, e_l2});
    chk("R6/R10", "inval",  {7'b0, l2_inval_o}, {7'b0, e_inv});
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_ni = 1'b0; addr_i = '0; wdata_i = '0; wr_en_i = 1'b0; rd_en_i = 1'b0;
    m_le = 0; m_light = 0; m_map = 0; m_sys = '0; m_rd = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "rdata",  rdata_o, 8'h00);
    chk("R1", "ctrl",   {little_endian_o, disk_light_o, map_type_o, sys_ctrl_o}, 8'h00);
    chk("R1", "strobe", {4'b0, soft_reset_o, nvram_lock1_tgl_o, nvram_lock2_tgl_o, l2_inval_o}, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk);
    step(16'h0000, 8'h00, 0, 0);

    // R3: fixed codes, and writes to ID ports ignored
    step(16'h0800, 8'h00, 1, 1);
    step(16'h0802, 8'hFF, 1, 1);
    step(16'h0803, 8'h5A, 1, 1);
    step(16'h080C, 8'h00, 0, 1);
    step(16'h0810, 8'h00, 0, 1);
    step(16'h0818, 8'h00, 0, 1);
    step(16'h0823, 8'h00, 0, 1);
    // R2: endian and soft reset
    step(16'h0092, 8'h03, 1, 0);
    step(16'h0092, 8'h00, 0, 1);
    step(16'h0092, 8'h01, 1, 0);
    step(16'h0092, 8'h02, 1, 0);
    // R4
    step(16'h0808, 8'hFF, 1, 1);
    step(16'h0808, 8'hFE, 1, 0);
    // R5, R6, R10: back-to-back strobes
    step(16'h0810, 8'h00, 1, 0);
    step(16'h0812, 8'h00, 1, 1);
    step(16'h0814, 8'hA5, 1, 1);
    step(16'h0814, 8'h00, 1, 0);
    step(16'h0000, 8'h00, 0, 0);
    // R7: upper bits dropped
    step(16'h081C, 8'hFA, 1, 0);
    step(16'h081C, 8'h00, 0, 1);
    // R8 / R11: read and write in the same cycle return the old value
    step(16'h0850, 8'hFF, 1, 1);
    step(16'h0850, 8'h00, 0, 1);
    // R9: unlisted ports
    step(16'h0851, 8'hFF, 1, 1);
    step(16'h0801, 8'hFF, 1, 1);
    step(16'h0093, 8'h03, 1, 1);
    step(16'h0000, 8'h00, 0, 0);

    for (int i = 0; i < 4000; i++) begin
      step(rand_addr(), 8'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule